// File: doc/BRIEF.md
# Two-Level Cache Line State Controller

This block keeps the coherence state of every line of a small inclusive cache pair: an inner first-level cache and an outer second-level cache. Each line holds one of four states in each level: Modified, Exclusive, Shared or Invalid. It takes one request at a time: a read, a write, or a first-level eviction, together with a line index and four attribute bits. From the current states of both levels and those attributes it chooses the bus transaction, if one is needed. The choices are a single read, a burst read or a single write. It then waits for the bus to report completion and only then writes the new state pair.

Two attribute bits decide whether the access may be cached at all: the request's own cache enable and the system's permission. The other two decide the write policy. The policy is write-back only when write-back is allowed and the page is not forced to write-through. Write-back lines land in Exclusive. Write-through lines land in Shared, and a write to a Shared line is also sent to the bus. A write that misses both levels under write-through needs two bus phases: a burst read, then a single write. Requests with no bus work finish in the cycle they are accepted. A look-up port returns the state pair of any line at any time.

Top module: `mesi2_ctrl`

## Requirements
- R1: After reset every line reads Invalid (code 0) in both levels, busy_o is low and act_o is 0 (none). Whenever busy_o is low, act_o is 0.
- R2: A read that finds both levels Invalid and is not cacheable raises busy_o with act_o = 1 (single read). Both states stay Invalid. Cacheable means cache_req_i and cache_ok_i are both high.
- R3: A cacheable read that finds both levels Invalid shows act_o = 2 (burst read). Both levels then take the fill state: Exclusive (2) when wb_allow_i is high and wt_force_i is low, Shared (1) otherwise. A valid first-level line always has a valid second-level line.
- R4: A read that finds the first level valid needs no bus cycle. busy_o stays low and neither state changes.
- R5: A read that finds the first level Invalid and the second level valid needs no bus cycle. The first level copies the second-level state, except that a Modified (3) second-level line gives Exclusive in the first level.
- R6: A write that finds both levels Invalid and is not cacheable shows act_o = 3 (single write). Both states stay Invalid.
- R7: A cacheable write-back write that finds both levels Invalid shows act_o = 2. Afterwards the first level is Modified and the second level is Exclusive.
- R8: A cacheable write-through write that finds both levels Invalid shows act_o = 2, then after the first completion act_o = 3. After the second completion both levels are Shared.
- R9: A write to a first-level line in Exclusive or Modified needs no bus cycle. The first level becomes Modified and the second level is unchanged.
- R10: A write to a first-level Shared line shows act_o = 3. The first level then takes the fill state, and so does the second level if it was valid.
- R11: A write that finds the first level Invalid and the second level in Exclusive or Modified needs no bus cycle and sets the second level to Modified. If the second level is Shared, the write shows act_o = 3 and the second level takes the fill state. The first level stays Invalid in both cases.
- R12: While busy_o is high, act_o and all states hold until bus_done_i is seen. Requests are ignored, including one in the same cycle as the completion.
- R13: An eviction (req_op_i = 2) sets the first level to Invalid with no bus cycle. A Modified first-level line makes the second level Modified. Op code 3 does nothing. Op 0 is read and op 1 is write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; taken only while idle |
| req_op_i | input | 2 | 0 read, 1 write, 2 first-level eviction, 3 no-op |
| req_idx_i | input | IDX_W | Line index of the request |
| cache_req_i | input | 1 | Request asks to be cached |
| cache_ok_i | input | 1 | System permits caching |
| wt_force_i | input | 1 | Page forced to write-through |
| wb_allow_i | input | 1 | System allows write-back |
| bus_done_i | input | 1 | Completion pulse for the current bus phase |
| peek_idx_i | input | IDX_W | Line index for the state look-up |
| busy_o | output | 1 | A bus phase is outstanding |
| act_o | output | 2 | 0 none, 1 single read, 2 burst read, 3 single write |
| l1_peek_o | output | 2 | First-level state of peek_idx_i |
| l2_peek_o | output | 2 | Second-level state of peek_idx_i |

## Verification
Two events can fall in the same cycle: the completion of a bus phase, and a new request arriving while the block is still busy. The bench holds a request on another line for the whole wait, including the cycle in which bus_done_i is pulsed. After the transaction it reads every line through the look-up port and checks that only the requested line changed. In every cycle it also compares busy_o and act_o with a behavioural model, so any early commit or any acceptance of the competing request shows up as a state or action mismatch.

// File: rtl/mesi2_pkg.sv
package mesi2_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_SRD = 2'd1, ACT_BRD = 2'd2, ACT_SWR = 2'd3} act_e;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EVICT = 2'd2, OP_NOP = 2'd3} op_e;

  typedef struct packed {
    act_e  first;
    logic  chain_wr;
    mesi_e l1_nx;
    mesi_e l2_nx;
  } plan_t;
endpackage

// File: rtl/mesi2_decide.sv
module mesi2_decide
  import mesi2_pkg::*;
(
  input  op_e   op_i,
  input  mesi_e l1_i,
  input  mesi_e l2_i,
  input  logic  cacheable_i,
  input  logic  wb_i,
  output plan_t plan_o
);
  mesi_e fill;
  assign fill = wb_i ? ST_E : ST_S;

  always_comb begin
    plan_o.first    = ACT_NONE;
    plan_o.chain_wr = 1'b0;
    plan_o.l1_nx    = l1_i;
    plan_o.l2_nx    = l2_i;
    case (op_i)
      OP_RD: begin
        if (l1_i != ST_I) begin
          plan_o.first = ACT_NONE;
        end else if (l2_i != ST_I) begin
          plan_o.l1_nx = (l2_i == ST_M) ? ST_E : l2_i;
        end else if (cacheable_i) begin
          plan_o.first = ACT_BRD;
          plan_o.l1_nx = fill;
          plan_o.l2_nx = fill;
        end else begin
          plan_o.first = ACT_SRD;
        end
      end
      OP_WR: begin
        if (l1_i == ST_E || l1_i == ST_M) begin
          plan_o.l1_nx = ST_M;
        end else if (l1_i == ST_S) begin
          plan_o.first = ACT_SWR;
          plan_o.l1_nx = fill;
          plan_o.l2_nx = (l2_i != ST_I) ? fill : ST_I;
        end else if (l2_i == ST_E || l2_i == ST_M) begin
          plan_o.l2_nx = ST_M;
        end else if (l2_i == ST_S) begin
          plan_o.first = ACT_SWR;
          plan_o.l2_nx = fill;
        end else if (!cacheable_i) begin
          plan_o.first = ACT_SWR;
        end else if (wb_i) begin
          plan_o.first = ACT_BRD;
          plan_o.l1_nx = ST_M;
          plan_o.l2_nx = ST_E;
        end else begin
          // burst fill, then the write goes through to the bus
          plan_o.first    = ACT_BRD;
          plan_o.chain_wr = 1'b1;
          plan_o.l1_nx    = ST_S;
          plan_o.l2_nx    = ST_S;
        end
      end
      OP_EVICT: begin
        plan_o.l1_nx = ST_I;
        if (l1_i == ST_M) plan_o.l2_nx = ST_M;
      end
      default: plan_o.first = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/mesi2_state_array.sv
module mesi2_state_array
  import mesi2_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic [IDX_W-1:0]   peek_idx_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  mesi_e              l1_wd_i,
  input  mesi_e              l2_wd_i,
  output mesi_e              l1_rd_o,
  output mesi_e              l2_rd_o,
  output logic [1:0]         l1_pk_o,
  output logic [1:0]         l2_pk_o,
  output logic [2*LINES-1:0] l1_vec_o,
  output logic [2*LINES-1:0] l2_vec_o
);
  logic [LINES-1:0][1:0] l1_q, l2_q;
  logic [LINES-1:0]      sel;

  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign sel[g] = we_i && (wr_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q <= '0;
      l2_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (sel[i]) begin
          l1_q[i] <= l1_wd_i;
          l2_q[i] <= l2_wd_i;
        end
      end
    end
  end

  assign l1_rd_o  = mesi_e'(l1_q[rd_idx_i]);
  assign l2_rd_o  = mesi_e'(l2_q[rd_idx_i]);
  assign l1_pk_o  = l1_q[peek_idx_i];
  assign l2_pk_o  = l2_q[peek_idx_i];
  assign l1_vec_o = l1_q;
  assign l2_vec_o = l2_q;
endmodule

// File: rtl/mesi2_seq.sv
module mesi2_seq
  import mesi2_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  plan_t            plan_i,
  input  logic             bus_done_i,
  output logic             busy_o,
  output act_e             act_o,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output mesi_e            l1_wd_o,
  output mesi_e            l2_wd_o
);
  plan_t            held_q;
  logic [IDX_W-1:0] idx_q;
  logic             chain_q;
  logic             accept, fast, finish;

  assign accept = req_valid_i && !busy_o;
  assign fast   = accept && (plan_i.first == ACT_NONE);
  assign finish = busy_o && bus_done_i && !chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      act_o   <= ACT_NONE;
      chain_q <= 1'b0;
      idx_q   <= '0;
      held_q  <= '0;
    end else if (accept) begin
      held_q <= plan_i;
      idx_q  <= req_idx_i;
      if (plan_i.first != ACT_NONE) begin
        busy_o  <= 1'b1;
        act_o   <= plan_i.first;
        chain_q <= plan_i.chain_wr;
      end
    end else if (busy_o && bus_done_i) begin
      if (chain_q) begin
        act_o   <= ACT_SWR;
        chain_q <= 1'b0;
      end else begin
        busy_o <= 1'b0;
        act_o  <= ACT_NONE;
      end
    end
  end

  assign we_o     = fast || finish;
  assign wr_idx_o = fast ? req_idx_i : idx_q;
  assign l1_wd_o  = fast ? plan_i.l1_nx : held_q.l1_nx;
  assign l2_wd_o  = fast ? plan_i.l2_nx : held_q.l2_nx;
endmodule

// File: rtl/mesi2_ctrl.sv
module mesi2_ctrl
  import mesi2_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             cache_req_i,
  input  logic             cache_ok_i,
  input  logic             wt_force_i,
  input  logic             wb_allow_i,
  input  logic             bus_done_i,
  input  logic [IDX_W-1:0] peek_idx_i,
  output logic             busy_o,
  output logic [1:0]       act_o,
  output logic [1:0]       l1_peek_o,
  output logic [1:0]       l2_peek_o
);
  mesi_e            l1_cur, l2_cur, l1_wd, l2_wd;
  plan_t            plan;
  logic             we;
  logic [IDX_W-1:0] wr_idx;
  act_e             act;
  logic [2*LINES-1:0] l1_vec, l2_vec;
  logic             cacheable, wb_mode;

  assign cacheable = cache_req_i && cache_ok_i;
  assign wb_mode   = wb_allow_i && !wt_force_i;

  mesi2_state_array #(.LINES(LINES)) u_arr (
    .clk_i, .rst_ni,
    .rd_idx_i(req_idx_i), .peek_idx_i(peek_idx_i),
    .we_i(we), .wr_idx_i(wr_idx), .l1_wd_i(l1_wd), .l2_wd_i(l2_wd),
    .l1_rd_o(l1_cur), .l2_rd_o(l2_cur),
    .l1_pk_o(l1_peek_o), .l2_pk_o(l2_peek_o),
    .l1_vec_o(l1_vec), .l2_vec_o(l2_vec)
  );

  mesi2_decide u_dec (
    .op_i(op_e'(req_op_i)), .l1_i(l1_cur), .l2_i(l2_cur),
    .cacheable_i(cacheable), .wb_i(wb_mode), .plan_o(plan)
  );

  mesi2_seq #(.LINES(LINES)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_idx_i, .plan_i(plan), .bus_done_i,
    .busy_o, .act_o(act), .we_o(we), .wr_idx_o(wr_idx),
    .l1_wd_o(l1_wd), .l2_wd_o(l2_wd)
  );

  assign act_o = act;
endmodule

// File: rtl/mesi2_ctrl_chk.sv
module mesi2_ctrl_chk #(
  parameter int LINES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_done_i,
  input logic               busy_o,
  input logic [1:0]         act_o,
  input logic [2*LINES-1:0] l1_vec,
  input logic [2*LINES-1:0] l2_vec
);
  logic incl_ok;
  always_comb begin
    incl_ok = 1'b1;
    for (int i = 0; i < LINES; i++)
      if (l1_vec[2*i +: 2] != 2'd0 && l2_vec[2*i +: 2] == 2'd0) incl_ok = 1'b0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> act_o == 2'd0);
  p_wait_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bus_done_i |=> busy_o && $stable(act_o) && $stable(l1_vec) && $stable(l2_vec));
  p_srd_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && act_o == 2'd1 && bus_done_i |=> !busy_o);
  p_swr_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && act_o == 2'd3 && bus_done_i |=> !busy_o);
  p_brd_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && act_o == 2'd2 && bus_done_i |=> !busy_o || act_o == 2'd3);
  p_inclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incl_ok);
endmodule

bind mesi2_ctrl mesi2_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_done_i(bus_done_i),
  .busy_o(busy_o), .act_o(act_o), .l1_vec(l1_vec), .l2_vec(l2_vec)
);

// File: tb/mesi2_ctrl_bench.sv
`timescale 1ns/1ps
module mesi2_ctrl_bench;
  localparam int LINES = 16;
  localparam int IW = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, cache_req = 0, cache_ok = 0, wt_force = 0, wb_allow = 0, bus_done = 0;
  logic [1:0] req_op = 0;
  logic [IW-1:0] req_idx = 0, peek_idx = 0;
  logic busy;
  logic [1:0] act, l1_pk, l2_pk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m1[LINES], m2[LINES];

  always #2.5 clk = ~clk;

  mesi2_ctrl #(.LINES(LINES)) u_mesi2_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_idx_i(req_idx), .cache_req_i(cache_req), .cache_ok_i(cache_ok),
    .wt_force_i(wt_force), .wb_allow_i(wb_allow), .bus_done_i(bus_done),
    .peek_idx_i(peek_idx), .busy_o(busy), .act_o(act),
    .l1_peek_o(l1_pk), .l2_peek_o(l2_pk)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
      summary();
      $finish;
    end
  end

  // behavioural reference of the state policy
  function automatic void model(input int k, input int l1, input int l2, input int cach, input int wbm,
                                output int a1, output int a2, output int n1, output int n2);
    int fill;
    fill = wbm ? 2 : 1;
    a1 = 0; a2 = 0; n1 = l1; n2 = l2;
    case (k)
      0: if (l1 == 0) begin
           if (l2 != 0) n1 = (l2 == 3) ? 2 : l2;
           else if (cach != 0) begin a1 = 2; n1 = fill; n2 = fill; end
           else a1 = 1;
         end
      1: if (l1 >= 2) n1 = 3;
         else if (l1 == 1) begin a1 = 3; n1 = fill; n2 = (l2 != 0) ? fill : 0; end
         else if (l2 >= 2) n2 = 3;
         else if (l2 == 1) begin a1 = 3; n2 = fill; end
         else if (cach == 0) a1 = 3;
         else if (wbm != 0) begin a1 = 2; n1 = 3; n2 = 2; end
         else begin a1 = 2; a2 = 3; n1 = 1; n2 = 1; end
      2: begin n1 = 0; if (l1 == 3) n2 = 3; end
      default: ;
    endcase
  endfunction

  task automatic scan(input string tag);
    for (int i = 0; i < LINES; i++) begin
      peek_idx = IW'(i);
      #0.1;
      chk(l1_pk == 2'(m1[i]), tag, $sformatf("L1 line %0d", i), l1_pk, m1[i]);
      chk(l2_pk == 2'(m2[i]), tag, $sformatf("L2 line %0d", i), l2_pk, m2[i]);
    end
  endtask

  // attrs: cq, ok, wt, wb; dly cycles before done; poke drives a competing request
  task automatic do_op(input int k, input int idx, input int cq, input int ok, input int wt, input int wb,
                       input int dly, input bit poke, input string tag);
    int a1, a2, n1, n2, ph;
    int cach, wbm;
    cach = (cq != 0 && ok != 0) ? 1 : 0;
    wbm  = (wb != 0 && wt == 0) ? 1 : 0;
    model(k, m1[idx], m2[idx], cach, wbm, a1, a2, n1, n2);
    @(negedge clk);
    req_valid = 1; req_op = 2'(k); req_idx = IW'(idx);
    cache_req = cq[0]; cache_ok = ok[0]; wt_force = wt[0]; wb_allow = wb[0];
    @(negedge clk);
    req_valid = 0;
    if (a1 == 0) begin
      chk(busy == 1'b0, tag, "busy with no bus work", busy, 0);
      chk(act == 2'd0, tag, "action with no bus work", act, 0);
    end else begin
      for (int p = 0; p < 2; p++) begin
        ph = (p == 0) ? a1 : a2;
        if (ph != 0) begin
          for (int c = 0; c <= dly; c++) begin
            chk(busy == 1'b1, tag, "busy while waiting", busy, 1);
            chk(act == 2'(ph), tag, "bus action", act, ph);
            peek_idx = IW'(idx);
            #0.1;
            chk(l1_pk == 2'(m1[idx]) && l2_pk == 2'(m2[idx]), "R12", "state held before done",
                {l1_pk, l2_pk}, m1[idx] * 4 + m2[idx]);
            if (poke) begin
              req_valid = 1; req_op = 2'd1; req_idx = IW'((idx + 1) % LINES);
              cache_req = 1; cache_ok = 1; wb_allow = 1; wt_force = 0;
            end
            if (c == dly) bus_done = 1;
            @(negedge clk);
            bus_done = 0;
          end
        end
      end
      req_valid = 0;
      chk(busy == 1'b0, tag, "busy after completion", busy, 0);
      chk(act == 2'd0, tag, "action after completion", act, 0);
    end
    m1[idx] = n1; m2[idx] = n2;
    scan(tag);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin m1[i] = 0; m2[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(act == 2'd0, "R1", "reset action", act, 0);
    scan("R1");
    do_op(0, 0, 1, 0, 0, 1, 1, 0, "R2");  // caching denied
    do_op(0, 7, 0, 1, 0, 1, 0, 0, "R2");
    do_op(0, 1, 1, 1, 0, 1, 2, 0, "R3");  // write-back fill -> E,E
    do_op(0, 2, 1, 1, 1, 1, 0, 0, "R3");  // forced write-through -> S,S
    do_op(0, 3, 1, 1, 0, 0, 1, 0, "R3");  // write-back not allowed -> S,S
    do_op(0, 1, 0, 0, 0, 0, 0, 0, "R4");
    do_op(0, 2, 1, 1, 0, 1, 0, 0, "R4");
    do_op(1, 1, 1, 1, 0, 1, 0, 0, "R9");  // E -> M
    do_op(1, 1, 0, 0, 1, 0, 0, 0, "R9");  // M stays M
    do_op(1, 2, 1, 1, 0, 1, 1, 1, "R10"); // S -> E via single write
    do_op(2, 1, 0, 0, 0, 0, 0, 0, "R13"); // M evicted: L2 -> M
    do_op(3, 2, 1, 1, 0, 1, 0, 0, "R13"); // no-op
    do_op(0, 1, 1, 1, 0, 1, 0, 0, "R5");  // L2 M -> L1 E
    do_op(2, 2, 0, 0, 0, 0, 0, 0, "R13"); // E evicted: L2 stays E
    do_op(0, 2, 0, 0, 0, 0, 0, 0, "R5");  // L2 E -> L1 E
    do_op(2, 3, 0, 0, 0, 0, 0, 0, "R13");
    do_op(0, 3, 0, 0, 0, 0, 0, 0, "R5");  // L2 S -> L1 S
    do_op(2, 3, 0, 0, 0, 0, 0, 0, "R13");
    do_op(1, 3, 1, 1, 1, 1, 1, 1, "R11"); // L2 S write-through stays S
    do_op(1, 3, 1, 1, 0, 1, 0, 0, "R11"); // L2 S -> E
    do_op(1, 3, 1, 1, 0, 1, 0, 0, "R11"); // L2 E -> M, no bus
    do_op(1, 4, 1, 0, 0, 1, 2, 1, "R6");
    do_op(1, 5, 1, 1, 0, 1, 1, 1, "R7");
    do_op(1, 6, 1, 1, 1, 1, 2, 1, "R8");
    do_op(1, 6, 1, 1, 0, 1, 0, 0, "R10"); // S/S hit -> E/E
    do_op(0, 9, 1, 1, 1, 0, 3, 1, "R12"); // competing request across a long wait
    summary();
    $finish;
  end
endmodule